// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

A bank of independent pulse channels, four by default, each producing a repeating waveform made of an active phase and an inactive phase whose lengths are programmed in servo ticks. Servo ticks come from a prescaler on the single system clock. A slow rate (one tick every `DIV_SLOW` clocks) is the default. A configuration bit switches to a fast rate (one tick every `DIV_FAST` clocks). Each channel runs in one of two modes. In free-running mode it repeats until stopped. In burst mode it emits a programmed number of pulses, then disables itself, returns its pin to the idle level and raises an end-of-burst event.

Software reaches the block over a flat 32-bit register bus with a write strobe and a combinational read port. It programs the lengths and the control word for each channel. The remaining pulse count of a burst can be read back while the burst runs. A hold register can park any set of channels. Channels released by the same write start their active phases on the same tick, so their edges line up. End-of-burst events latch into a status register, are cleared by writing 1 and are gated by a mask onto a single interrupt line.

Top module: `servo_bank`

## Requirements
- R1: After reset every pin is 0, the interrupt is 0, and every register reads 0.
- R2: An enabled channel holds its pin active for max(high,1) ticks, then inactive for max(low,1) ticks. In free-running mode (control bit 30 set) this pattern repeats without end.
- R3: A write to the control word with bit 31 set arms the channel. Its active phase begins on the first servo tick after the write.
- R4: Word 2 holds one hold bit per channel. While its hold bit is 1, a channel does not advance. A channel left armed while held begins its active phase on the first tick after release, so channels released by one write rise on the same cycle.
- R5: In burst mode (bit 30 clear) a channel emits max(N,1) pulses, where N is bits 27..0. It then clears bit 31, drives its idle level and sets its bit in the status register at word 1.
- R6: While a burst runs, bits 27..0 of the control word read back the pulses not yet finished, including the current one. The field reads 0 once the burst has ended.
- R7: Control bit 29 inverts the pin in every state, including idle.
- R8: A high or low length of 0 behaves as one tick.
- R9: The interrupt output is the OR of status bits whose mask bits (word 0) are 1. Writing 1 to a status bit clears it. A status bit set and cleared in the same cycle stays set.
- R10: Bit 0 of word 3 selects the fast tick rate (every DIV_FAST clocks). When it is 0, the slow rate applies (every DIV_SLOW clocks).
- R11: Writing a control word with bit 31 clear stops the channel at once and returns its pin to the idle level.

Register words (byte address = 4 × word): 0 mask, 1 status, 2 hold, 3 rate select. Channel k uses word 4+3k for the high length, 5+3k for the low length and 6+3k for the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| servo_out | output | NCH | One pulse output per channel |
| irq | output | 1 | Masked OR of the end-of-burst status bits |

## Verification
The hardest case to reach is a write-1-to-clear of a status bit that arrives on the exact cycle its end-of-burst event lands. The bench runs a one-pulse burst with one-tick phases at the fast rate. From the cycle of the arming write it counts four edges and places the clear write on the edge where the status bit is set. It then expects the bit to survive. Aligned release from hold is reached by arming two channels of different lengths while both are held, then dropping both hold bits in a single write.

// File: rtl/servo_pkg.sv
// Shared constants and state type for the servo pulse bank.
// Assumes a 32-bit register bus with word-granular addressing.
package servo_pkg;
    localparam int DATA_W   = 32;
    localparam int REP_W    = 28;
    localparam int CTL_EN   = 31;
    localparam int CTL_CONT = 30;
    localparam int CTL_INV  = 29;

    localparam int W_MASK   = 0;
    localparam int W_STATUS = 1;
    localparam int W_HOLD   = 2;
    localparam int W_RATE   = 3;
    localparam int W_CH0    = 4;
    localparam int W_PER_CH = 3;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_HIGH  = 2'd2,
        CH_LOW   = 2'd3
    } ch_state_t;
endpackage

// File: rtl/servo_tick_gen.sv
// Servo tick prescaler: one-cycle tick every DIV_SLOW or DIV_FAST clocks.
// Assumes DIV_SLOW >= DIV_FAST >= 1; a rate change takes effect at once.
module servo_tick_gen #(
    parameter int DIV_SLOW = 5,
    parameter int DIV_FAST = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_SLOW + 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(DIV_FAST - 1);

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] limit;

    // Select the terminal count for the current rate.
    always_comb begin
        limit = fast_sel ? LIM_FAST : LIM_SLOW;
        tick  = (pcnt >= limit);
    end

    // Advance the prescaler and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + CNT_W'(1);
    end
endmodule

// File: rtl/servo_channel.sv
// One pulse channel: owns its control word and phase sequencer.
// Assumes length inputs are stable registers; a control write restarts it.
module servo_channel
    import servo_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [CNT_W-1:0]  high_len,
    input  logic [CNT_W-1:0]  low_len,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              pwm,
    output logic              done,
    output logic              en_o,
    output logic              inv_o
);
    ch_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [REP_W-1:0]  rem;
    logic              en_q, cont_q, inv_q;
    logic [CNT_W-1:0]  hi_eff, lo_eff;

    // Clamp zero lengths to a single tick.
    always_comb begin
        hi_eff = (high_len == '0) ? CNT_W'(1) : high_len;
        lo_eff = (low_len  == '0) ? CNT_W'(1) : low_len;
    end

    // Sequence the phases; a control write has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CH_IDLE;
            cnt    <= '0;
            rem    <= '0;
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            inv_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ctl_we) begin
                en_q   <= ctl_wdata[CTL_EN];
                cont_q <= ctl_wdata[CTL_CONT];
                inv_q  <= ctl_wdata[CTL_INV];
                rem    <= ctl_wdata[REP_W-1:0];
                cnt    <= '0;
                state  <= ctl_wdata[CTL_EN] ? CH_ARMED : CH_IDLE;
            end else if (tick && !hold) begin
                unique case (state)
                    CH_ARMED: begin
                        state <= CH_HIGH;
                        cnt   <= CNT_W'(1);
                    end
                    CH_HIGH: begin
                        if (cnt >= hi_eff) begin
                            state <= CH_LOW;
                            cnt   <= CNT_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    CH_LOW: begin
                        if (cnt < lo_eff) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (cont_q) begin
                            state <= CH_HIGH;
                            cnt   <= CNT_W'(1);
                        end else if (rem <= REP_W'(1)) begin
                            state <= CH_IDLE;
                            cnt   <= '0;
                            rem   <= '0;
                            en_q  <= 1'b0;
                            done  <= 1'b1;
                        end else begin
                            state <= CH_HIGH;
                            cnt   <= CNT_W'(1);
                            rem   <= rem - REP_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Drive the pin and expose the control word.
    always_comb begin
        pwm       = inv_q ^ (state == CH_HIGH);
        ctl_rdata = {en_q, cont_q, inv_q, 1'b0, rem};
        en_o      = en_q;
        inv_o     = inv_q;
    end
endmodule

// File: rtl/servo_irq_ctrl.sv
// End-of-burst status with write-1-to-clear, mask and combined interrupt.
// Assumes done pulses last one cycle; a set beats a clear in the same cycle.
module servo_irq_ctrl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done,
    input  logic           mask_we,
    input  logic           status_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] status,
    output logic           irq
);
    logic [NCH-1:0] clr;

    // Form the clear vector from a status write.
    always_comb clr = status_we ? wdata : '0;

    // Hold mask and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            status <= '0;
        end else begin
            if (mask_we) mask <= wdata;
            status <= (status & ~clr) | done;
        end
    end

    // Combine enabled events onto the interrupt line.
    always_comb irq = |(status & mask);
endmodule

// File: rtl/servo_bank.sv
// Top of the servo pulse bank: register decode, shared hold/rate, channels.
// Assumes NCH <= 20 so that all words fit in the address field.
module servo_bank
    import servo_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int ADDR_W   = 8,
    parameter int DIV_SLOW = 5,
    parameter int DIV_FAST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    servo_out,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic              tick;
    logic              fast_q;
    logic [NCH-1:0]    hold_q;
    logic [NCH-1:0]    ch_done, ch_en, ch_inv;
    logic [NCH-1:0]    irq_mask, irq_status;
    logic [31:0]       high_q [NCH];
    logic [31:0]       low_q  [NCH];
    logic [31:0]       ctl_rd [NCH];

    assign widx = bus_addr[ADDR_W-1:2];

    // Keep the shared hold and rate-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            fast_q <= 1'b0;
        end else if (bus_we) begin
            if (int'(widx) == W_HOLD) hold_q <= bus_wdata[NCH-1:0];
            if (int'(widx) == W_RATE) fast_q <= bus_wdata[0];
        end
    end

    servo_tick_gen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fast_q),
        .tick     (tick)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int W_HI  = W_CH0 + W_PER_CH * k;
        localparam int W_LO  = W_HI + 1;
        localparam int W_CTL = W_HI + 2;

        // Keep this channel's length registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                high_q[k] <= '0;
                low_q[k]  <= '0;
            end else if (bus_we) begin
                if (int'(widx) == W_HI) high_q[k] <= bus_wdata;
                if (int'(widx) == W_LO) low_q[k]  <= bus_wdata;
            end
        end

        servo_channel #(
            .CNT_W (32)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .hold      (hold_q[k]),
            .ctl_we    (bus_we && (int'(widx) == W_CTL)),
            .ctl_wdata (bus_wdata),
            .high_len  (high_q[k]),
            .low_len   (low_q[k]),
            .ctl_rdata (ctl_rd[k]),
            .pwm       (servo_out[k]),
            .done      (ch_done[k]),
            .en_o      (ch_en[k]),
            .inv_o     (ch_inv[k])
        );
    end

    servo_irq_ctrl #(
        .NCH (NCH)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (ch_done),
        .mask_we   (bus_we && (int'(widx) == W_MASK)),
        .status_we (bus_we && (int'(widx) == W_STATUS)),
        .wdata     (bus_wdata[NCH-1:0]),
        .mask      (irq_mask),
        .status    (irq_status),
        .irq       (irq)
    );

    // Select the read word.
    always_comb begin
        bus_rdata = '0;
        case (int'(widx))
            W_MASK:   bus_rdata = 32'(irq_mask);
            W_STATUS: bus_rdata = 32'(irq_status);
            W_HOLD:   bus_rdata = 32'(hold_q);
            W_RATE:   bus_rdata = {31'd0, fast_q};
            default:  ;
        endcase
        for (int k = 0; k < NCH; k++) begin
            if (int'(widx) == W_CH0 + W_PER_CH * k)     bus_rdata = high_q[k];
            if (int'(widx) == W_CH0 + W_PER_CH * k + 1) bus_rdata = low_q[k];
            if (int'(widx) == W_CH0 + W_PER_CH * k + 2) bus_rdata = ctl_rd[k];
        end
    end
endmodule

// File: rtl/servo_bank_chk.sv
// Assertion checker for servo_bank, attached by bind.
// Assumes it sees the top's tick, hold, channel flags and status by name.
module servo_bank_chk #(
    parameter int NCH      = 4,
    parameter int DIV_SLOW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_we,
    input logic           tick,
    input logic           fast_q,
    input logic [NCH-1:0] hold_q,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] ch_inv,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] irq_status,
    input logic [NCH-1:0] servo_out,
    input logic           irq
);
    AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_we) |=> $stable(servo_out)); // R2

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !bus_we) |=> (!irq || $past(|ch_done))); // R9

    if (DIV_SLOW > 1) begin : g_rate
        AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !fast_q && !bus_we) |=> !tick); // R10
    end

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> (servo_out[i] == ch_inv[i])); // R11

        AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            ch_done[i] |=> irq_status[i]); // R5

        AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_q[i] && !bus_we) |=> $stable(servo_out[i])); // R4
    end
endmodule

bind servo_bank servo_bank_chk #(
    .NCH      (NCH),
    .DIV_SLOW (DIV_SLOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .tick       (tick),
    .fast_q     (fast_q),
    .hold_q     (hold_q),
    .ch_en      (ch_en),
    .ch_inv     (ch_inv),
    .ch_done    (ch_done),
    .irq_status (irq_status),
    .servo_out  (servo_out),
    .irq        (irq)
);

// File: tb/servo_bank_bench.sv
// Bench for servo_bank: behavioural model compared each cycle plus directed checks.
module servo_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DS  = 5;
    localparam int DF  = 1;
    localparam int MAX_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] servo_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit model_on = 0;
    bit finished = 0;

    servo_bank #(.NCH(NCH), .ADDR_W(8), .DIV_SLOW(DS), .DIV_FAST(DF)) u_servo_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .servo_out(servo_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state: 0 idle, 1 armed, 2 active, 3 inactive.
    int     m_st   [NCH];
    longint m_cnt  [NCH];
    longint m_hi   [NCH];
    longint m_lo   [NCH];
    int     m_rem  [NCH];
    bit     m_en   [NCH];
    bit     m_cont [NCH];
    bit     m_inv  [NCH];
    bit [NCH-1:0] m_hold, m_mask, m_status, m_donep, m_done;
    bit     m_fast;
    int     m_pc, m_lim, m_idx;
    bit     m_tick;
    longint m_he, m_le;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model update on each clock edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_st[c] = 0; m_cnt[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_rem[c] = 0;
                m_en[c] = 0; m_cont[c] = 0; m_inv[c] = 0;
            end
            m_hold = 0; m_mask = 0; m_status = 0; m_donep = 0; m_fast = 0; m_pc = 0;
        end else begin
            m_lim  = m_fast ? DF - 1 : DS - 1;
            m_tick = (m_pc >= m_lim);
            m_pc   = m_tick ? 0 : m_pc + 1;
            m_idx  = bus_we ? int'(bus_addr >> 2) : -1;
            m_done = 0;
            for (int c = 0; c < NCH; c++) begin
                m_he = (m_hi[c] == 0) ? 1 : m_hi[c];
                m_le = (m_lo[c] == 0) ? 1 : m_lo[c];
                if (m_idx == 6 + 3*c) begin
                    m_en[c] = bus_wdata[31]; m_cont[c] = bus_wdata[30]; m_inv[c] = bus_wdata[29];
                    m_rem[c] = int'(bus_wdata[27:0]); m_cnt[c] = 0;
                    m_st[c] = bus_wdata[31] ? 1 : 0;
                end else if (m_tick && !m_hold[c]) begin
                    if (m_st[c] == 1) begin
                        m_st[c] = 2; m_cnt[c] = 1;
                    end else if (m_st[c] == 2) begin
                        if (m_cnt[c] >= m_he) begin m_st[c] = 3; m_cnt[c] = 1; end
                        else m_cnt[c]++;
                    end else if (m_st[c] == 3) begin
                        if (m_cnt[c] < m_le) m_cnt[c]++;
                        else if (m_cont[c]) begin m_st[c] = 2; m_cnt[c] = 1; end
                        else if (m_rem[c] <= 1) begin
                            m_st[c] = 0; m_cnt[c] = 0; m_rem[c] = 0; m_en[c] = 0; m_done[c] = 1;
                        end else begin
                            m_st[c] = 2; m_cnt[c] = 1; m_rem[c]--;
                        end
                    end
                end
            end
            if (m_idx == 1) m_status = m_status & ~bus_wdata[NCH-1:0];
            m_status = m_status | m_donep;
            m_donep  = m_done;
            if (m_idx == 0) m_mask = bus_wdata[NCH-1:0];
            if (m_idx == 2) m_hold = bus_wdata[NCH-1:0];
            if (m_idx == 3) m_fast = bus_wdata[0];
            for (int c = 0; c < NCH; c++) begin
                if (m_idx == 4 + 3*c) m_hi[c] = longint'(bus_wdata);
                if (m_idx == 5 + 3*c) m_lo[c] = longint'(bus_wdata);
            end
        end
    end

    // Compare pins and interrupt against the model away from the edge.
    always @(negedge clk) begin
        if (model_on && !finished) begin
            for (int c = 0; c < NCH; c++)
                check("R2 pin vs model", 32'(servo_out[c]), 32'(m_inv[c] ^ (m_st[c] == 2)));
            check("R9 irq vs model", 32'(irq), 32'(|(m_status & m_mask)));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > MAX_CYC && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYC);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic bus_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        bus_addr = 8'(idx * 4);
        #1;
        d = bus_rdata;
    endtask

    // Count consecutive cycles at a level, starting at a fresh transition.
    task automatic level_width(input int ch, input logic lvl, output int w);
        int guard = 0;
        while (servo_out[ch] === lvl && guard < 500) begin @(negedge clk); guard++; end
        while (servo_out[ch] !== lvl && guard < 1000) begin @(negedge clk); guard++; end
        w = 0;
        while (servo_out[ch] === lvl && guard < 1500) begin w++; @(negedge clk); guard++; end
    endtask

    function automatic int hi_w(input int c);  return 4 + 3*c; endfunction
    function automatic int lo_w(input int c);  return 5 + 3*c; endfunction
    function automatic int ctl_w(input int c); return 6 + 3*c; endfunction

    localparam logic [31:0] EN   = 32'h8000_0000;
    localparam logic [31:0] CONT = 32'h4000_0000;
    localparam logic [31:0] INV  = 32'h2000_0000;

    initial begin
        logic [31:0] rd;
        int w, pulses;
        logic prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);

        // R1: reset state.
        check("R1 pins", 32'(servo_out), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        for (int i = 0; i < 4 + 3*NCH; i++) begin
            bus_read(i, rd);
            check("R1 register", rd, 32'd0);
        end

        // R10: slow rate, high 2 ticks = 10 clocks, low 1 tick = 5 clocks.
        bus_write(hi_w(0), 32'd2);
        bus_write(lo_w(0), 32'd1);
        bus_write(ctl_w(0), EN | CONT);
        level_width(0, 1'b1, w);
        check("R10 slow active width", 32'(w), 32'd10);
        level_width(0, 1'b0, w);
        check("R10 slow inactive width", 32'(w), 32'd5);
        bus_write(ctl_w(0), 32'd0);
        check("R11 stop to idle", 32'(servo_out[0]), 32'd0);

        // Fast rate: one tick per clock.
        bus_write(3, 32'd1);

        // R3: arming then first tick.
        bus_write(hi_w(0), 32'd3);
        bus_write(lo_w(0), 32'd2);
        bus_write(ctl_w(0), EN | CONT);
        check("R3 armed still idle", 32'(servo_out[0]), 32'd0);
        @(negedge clk);
        check("R3 active on next tick", 32'(servo_out[0]), 32'd1);
        level_width(0, 1'b1, w);
        check("R2 active width", 32'(w), 32'd3);
        level_width(0, 1'b0, w);
        check("R2 inactive width", 32'(w), 32'd2);
        level_width(0, 1'b1, w);
        check("R2 repeats active", 32'(w), 32'd3);
        bus_write(ctl_w(0), 32'd0);
        check("R11 stop mid-run", 32'(servo_out[0]), 32'd0);
        repeat (4) @(negedge clk);
        check("R11 stays idle", 32'(servo_out[0]), 32'd0);

        // R8: zero lengths act as one tick.
        bus_write(ctl_w(3), EN | CONT);
        level_width(3, 1'b1, w);
        check("R8 zero active length", 32'(w), 32'd1);
        level_width(3, 1'b0, w);
        check("R8 zero inactive length", 32'(w), 32'd1);
        bus_write(ctl_w(3), 32'd0);

        // R7: inversion while idle and while running.
        bus_write(ctl_w(2), INV);
        check("R7 inverted idle", 32'(servo_out[2]), 32'd1);
        bus_write(hi_w(2), 32'd2);
        bus_write(lo_w(2), 32'd3);
        bus_write(ctl_w(2), EN | CONT | INV);
        level_width(2, 1'b0, w);
        check("R7 inverted active width", 32'(w), 32'd2);
        level_width(2, 1'b1, w);
        check("R7 inverted inactive width", 32'(w), 32'd3);
        bus_write(ctl_w(2), 32'd0);

        // R5, R6: burst of three pulses.
        bus_write(hi_w(1), 32'd2);
        bus_write(lo_w(1), 32'd2);
        bus_write(ctl_w(1), EN | 32'd3);
        bus_read(ctl_w(1), rd);
        check("R6 count at start", rd, EN | 32'd3);
        pulses = 0; prev = servo_out[1];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (servo_out[1] && !prev) begin
                pulses++;
                if (pulses == 2) begin
                    bus_read(ctl_w(1), rd);
                    check("R6 count mid-burst", rd, EN | 32'd2);
                end
            end
            prev = servo_out[1];
        end
        check("R5 pulse count", 32'(pulses), 32'd3);
        check("R5 idle after burst", 32'(servo_out[1]), 32'd0);
        bus_read(ctl_w(1), rd);
        check("R5 enable cleared, R6 count zero", rd, 32'd0);
        bus_read(1, rd);
        check("R5 status set", rd, 32'h2);
        check("R9 masked off", 32'(irq), 32'd0);
        bus_write(0, 32'h2);
        check("R9 irq when unmasked", 32'(irq), 32'd1);
        bus_write(1, 32'h2);
        check("R9 cleared by write 1", 32'(irq), 32'd0);
        bus_read(1, rd);
        check("R9 status zero", rd, 32'd0);

        // R5: zero repeat count gives one pulse.
        bus_write(hi_w(3), 32'd1);
        bus_write(lo_w(3), 32'd1);
        bus_write(ctl_w(3), EN);
        pulses = 0; prev = servo_out[3];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (servo_out[3] && !prev) pulses++;
            prev = servo_out[3];
        end
        check("R5 zero count one pulse", 32'(pulses), 32'd1);
        bus_read(1, rd);
        check("R5 zero count status", rd, 32'h8);
        bus_write(1, 32'hF);

        // R9: clear write on the same edge the event lands.
        bus_write(hi_w(1), 32'd1);
        bus_write(lo_w(1), 32'd1);
        bus_write(ctl_w(1), EN | 32'd1);
        repeat (3) @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'd4; bus_wdata = 32'hF;
        @(negedge clk);
        bus_we = 1'b0;
        bus_read(1, rd);
        check("R9 set beats clear", rd, 32'h2);
        check("R9 irq after collision", 32'(irq), 32'd1);
        bus_write(1, 32'hF);

        // R4: hold, then aligned release.
        bus_write(2, 32'h3);
        bus_write(hi_w(0), 32'd4);
        bus_write(lo_w(0), 32'd4);
        bus_write(hi_w(1), 32'd1);
        bus_write(lo_w(1), 32'd6);
        bus_write(ctl_w(0), EN | CONT);
        bus_write(ctl_w(1), EN | CONT);
        repeat (8) @(negedge clk);
        check("R4 held channels idle", 32'(servo_out[1:0]), 32'd0);
        bus_write(2, 32'h0);
        check("R4 released, not yet ticked", 32'(servo_out[1:0]), 32'd0);
        @(negedge clk);
        check("R4 aligned start", 32'(servo_out[1:0]), 32'h3);
        bus_write(2, 32'h1);
        rd = 32'(servo_out[0]);
        repeat (6) @(negedge clk);
        check("R4 frozen mid-run", 32'(servo_out[0]), rd);
        bus_write(2, 32'h0);
        repeat (20) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule